// File: doc/BRIEF.md
# Processor Interrupt Interface

This block is the per-processor side of an interrupt controller. Each cycle the distributor offers it one candidate: an ID, a priority and a valid flag. The block decides whether to raise the interrupt request line to its processor. It raises the line only when three things are true: a global enable is on, the candidate clears a programmable priority mask, and the candidate is strictly more urgent than the interrupt the processor is already servicing.

The processor takes an interrupt with an acknowledge strobe. The returned ID appears on a read-data port one cycle later. At the same time a one-cycle acknowledge pulse carries that ID back to the distributor, and the interrupt's priority becomes the new running priority. The processor ends an interrupt by writing its ID on the end-of-interrupt port. This removes the active state, restores the previous running priority and sends a one-cycle deactivate pulse with the ID to the distributor. Active interrupts are kept in a small last-in-first-out stack, so nested preemption unwinds in order.

Top module: `irqc_cpu_port`

## Requirements
- R1: After reset, `irq_o` is 0, `ack_data_o` reads 1023 (the spurious ID), and both distributor pulses `dist_ack_vld_o` and `dist_deact_vld_o` are 0.
- R2: A lower priority number means more urgency. `irq_o` is 1 one cycle after `cpu_en_i`=1, `cand_vld_i`=1 and `cand_prio_i` < `prio_mask_i` (strictly less) all hold, provided R6 and R9 allow it. A candidate whose priority equals the mask is not signalled, and nothing is signalled while `cpu_en_i`=0.
- R3: An acknowledge (`ack_rd_i`=1) taken while a candidate qualifies has three effects in the next cycle: the candidate's ID on `ack_data_o`, and `dist_ack_vld_o` high for exactly one cycle with `dist_ack_id_o` equal to that ID.
- R4: `irq_o` is 0 in the cycle after an acknowledge is taken.
- R5: An acknowledge taken when no candidate qualifies returns 1023 on `ack_data_o`, produces no distributor pulse and changes no state.
- R6: While any interrupt is active, a candidate is signalled only if its priority number is strictly below that of the most recent active interrupt. A candidate of equal priority is not signalled.
- R7: An end-of-interrupt (`eoi_wr_i`=1) whose `eoi_id_i` matches the most recently acknowledged active ID does three things one cycle later: it pulses `dist_deact_vld_o` for one cycle with `dist_deact_id_o` equal to that ID, it removes that interrupt, and it restores the previous running priority.
- R8: An end-of-interrupt whose ID does not match the most recent active ID is ignored: no deactivate pulse, and the set of active interrupts is unchanged.
- R9: At most 4 interrupts are active at once. While 4 are active, `irq_o` stays 0 and an acknowledge returns 1023.
- R10: If an acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is processed and the end-of-interrupt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en_i | input | 1 | Global enable for the request line |
| prio_mask_i | input | PRIO_W | Priority mask; only numbers strictly below it are signalled |
| cand_vld_i | input | 1 | Distributor candidate is valid |
| cand_id_i | input | ID_W | Candidate interrupt ID |
| cand_prio_i | input | PRIO_W | Candidate priority (lower is more urgent) |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | ID_W | ID written with end-of-interrupt |
| irq_o | output | 1 | Registered interrupt request to the processor |
| ack_data_o | output | ID_W | Result of the last acknowledge read |
| dist_ack_vld_o | output | 1 | One-cycle acknowledge pulse to the distributor |
| dist_ack_id_o | output | ID_W | ID carried by the acknowledge pulse |
| dist_deact_vld_o | output | 1 | One-cycle deactivate pulse to the distributor |
| dist_deact_id_o | output | ID_W | ID carried by the deactivate pulse |

## Verification
The bench builds the block with its defaults: a 10-bit ID, an 8-bit priority and an active stack 4 deep. With a 10-bit ID the spurious code 1023 can be returned. With a depth of 4 the bench can fill the stack by nesting four preemptions, see the request line stay low against an even more urgent candidate, and then unwind the stack one end-of-interrupt at a time. The 8-bit priority lets it probe the mask boundary (equal versus one less) and the equal-priority non-preemption case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int unsigned IRQC_SPURIOUS = 1023;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_ACK  = 2'd1,
      OP_EOI  = 2'd2,
      OP_SPUR = 2'd3
   } irqc_op_e;

endpackage

// File: rtl/irqc_run_stack.sv
module irqc_run_stack #(
   parameter int ID_W   = 10,
   parameter int PRIO_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ID_W-1:0]   push_id_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic              top_vld_o,
   output logic [ID_W-1:0]   top_id_o,
   output logic [PRIO_W-1:0] top_prio_o,
   output logic              full_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("irqc_run_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [ID_W-1:0]   id_q   [DEPTH];
   logic [PRIO_W-1:0] prio_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push_i && !full_o) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && top_vld_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_q[i]   <= '0;
               prio_q[i] <= '1;
            end else if (push_i && cnt_q == CNT_W'(i)) begin
               id_q[i]   <= push_id_i;
               prio_q[i] <= push_prio_i;
            end
         end
      end
   endgenerate

   always_comb begin
      top_id_o   = '0;
      top_prio_o = '1;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CNT_W'(i + 1)) begin
            top_id_o   = id_q[i];
            top_prio_o = prio_q[i];
         end
      end
   end

   assign top_vld_o = (cnt_q != '0);
   assign full_o    = (cnt_q == DEPTH_C);

   a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DEPTH_C);
   a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   a_r7_pop_only_when_live: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> top_vld_o);

endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify #(
   parameter int PRIO_W = 8
) (
   input  logic              en_i,
   input  logic              vld_i,
   input  logic [PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0] mask_i,
   input  logic              run_vld_i,
   input  logic [PRIO_W-1:0] run_prio_i,
   input  logic              full_i,
   output logic              hit_o
);
   logic beats_mask;
   logic beats_run;

   assign beats_mask = (prio_i < mask_i);
   assign beats_run  = !run_vld_i || (prio_i < run_prio_i);
   assign hit_o      = en_i && vld_i && beats_mask && beats_run && !full_i;

endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
   import irqc_pkg::*;
#(
   parameter int ID_W   = 10,
   parameter int PRIO_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_en_i,
   input  logic [PRIO_W-1:0] prio_mask_i,
   input  logic              cand_vld_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic              ack_rd_i,
   input  logic              eoi_wr_i,
   input  logic [ID_W-1:0]   eoi_id_i,
   output logic              irq_o,
   output logic [ID_W-1:0]   ack_data_o,
   output logic              dist_ack_vld_o,
   output logic [ID_W-1:0]   dist_ack_id_o,
   output logic              dist_deact_vld_o,
   output logic [ID_W-1:0]   dist_deact_id_o
);
   localparam logic [ID_W-1:0] SPUR_ID = ID_W'(IRQC_SPURIOUS);

   generate
      if (ID_W < 10) begin : g_bad_idw
         $error("irqc_cpu_port: ID_W must hold the spurious code");
      end
      if (PRIO_W < 1) begin : g_bad_pw
         $error("irqc_cpu_port: PRIO_W must be at least 1");
      end
   endgenerate

   logic              hit;
   logic              top_vld;
   logic [ID_W-1:0]   top_id;
   logic [PRIO_W-1:0] top_prio;
   logic              full;
   irqc_op_e          op;

   irqc_qualify #(.PRIO_W(PRIO_W)) u_qual (
      .en_i       (cpu_en_i),
      .vld_i      (cand_vld_i),
      .prio_i     (cand_prio_i),
      .mask_i     (prio_mask_i),
      .run_vld_i  (top_vld),
      .run_prio_i (top_prio),
      .full_i     (full),
      .hit_o      (hit)
   );

   // acknowledge outranks end-of-interrupt in the same cycle
   always_comb begin
      if (ack_rd_i)
         op = hit ? OP_ACK : OP_SPUR;
      else if (eoi_wr_i && top_vld && eoi_id_i == top_id)
         op = OP_EOI;
      else
         op = OP_IDLE;
   end

   irqc_run_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (op == OP_ACK),
      .push_id_i   (cand_id_i),
      .push_prio_i (cand_prio_i),
      .pop_i       (op == OP_EOI),
      .top_vld_o   (top_vld),
      .top_id_o    (top_id),
      .top_prio_o  (top_prio),
      .full_o      (full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o            <= 1'b0;
         ack_data_o       <= SPUR_ID;
         dist_ack_vld_o   <= 1'b0;
         dist_ack_id_o    <= '0;
         dist_deact_vld_o <= 1'b0;
         dist_deact_id_o  <= '0;
      end else begin
         irq_o            <= hit && (op != OP_ACK);
         dist_ack_vld_o   <= (op == OP_ACK);
         dist_deact_vld_o <= (op == OP_EOI);
         if (op == OP_ACK) begin
            ack_data_o    <= cand_id_i;
            dist_ack_id_o <= cand_id_i;
         end else if (op == OP_SPUR) begin
            ack_data_o    <= SPUR_ID;
         end
         if (op == OP_EOI)
            dist_deact_id_o <= top_id;
      end
   end

   a_r2_enable_gates_line: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(cpu_en_i));
   a_r3_ack_id_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      dist_ack_vld_o |-> (ack_data_o == dist_ack_id_o));
   a_r4_line_drops_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ACK) |=> !irq_o);
   a_r5_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd_i && !hit) |=> (ack_data_o == SPUR_ID) && !dist_ack_vld_o);
   a_r7_deact_from_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      dist_deact_vld_o |-> $past(eoi_wr_i) && ($past(eoi_id_i) == dist_deact_id_o));
   a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd_i |=> !dist_deact_vld_o);

endmodule

// File: tb/irqc_cpu_port_tb.sv
module irqc_cpu_port_tb_top;
   localparam int ID_W = 10;
   localparam int PW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_en = 1'b0;
   logic [PW-1:0] mask = '1;
   logic          cvld = 1'b0;
   logic [ID_W-1:0] cid = '0;
   logic [PW-1:0] cprio = '0;
   logic          ack_rd = 1'b0;
   logic          eoi_wr = 1'b0;
   logic [ID_W-1:0] eoi_id = '0;
   logic          irq;
   logic [ID_W-1:0] ack_data;
   logic          ack_vld;
   logic [ID_W-1:0] ack_id;
   logic          deact_vld;
   logic [ID_W-1:0] deact_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irqc_cpu_port #(.ID_W(ID_W), .PRIO_W(PW), .DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_en_i(cpu_en), .prio_mask_i(mask),
      .cand_vld_i(cvld), .cand_id_i(cid), .cand_prio_i(cprio),
      .ack_rd_i(ack_rd), .eoi_wr_i(eoi_wr), .eoi_id_i(eoi_id),
      .irq_o(irq), .ack_data_o(ack_data), .dist_ack_vld_o(ack_vld),
      .dist_ack_id_o(ack_id), .dist_deact_vld_o(deact_vld),
      .dist_deact_id_o(deact_id)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cand(bit v, int id, int p);
      cvld  = v;
      cid   = ID_W'(id);
      cprio = PW'(p);
      @(negedge clk);
   endtask

   task automatic do_ack(int exp_data, bit exp_pulse, string req);
      ack_rd = 1'b1;
      @(negedge clk);
      ack_rd = 1'b0;
      chk({req, " ack_data"}, ack_data, exp_data);
      chk({req, " ack pulse"}, ack_vld, exp_pulse);
      if (exp_pulse) chk({req, " ack pulse id"}, ack_id, exp_data);
      chk({req, " irq low after ack"}, irq, 0);
      @(negedge clk);
      chk({req, " ack pulse one cycle"}, ack_vld, 0);
   endtask

   task automatic do_eoi(int id, bit exp_pulse, string req);
      eoi_wr = 1'b1;
      eoi_id = ID_W'(id);
      @(negedge clk);
      eoi_wr = 1'b0;
      chk({req, " deact pulse"}, deact_vld, exp_pulse);
      if (exp_pulse) chk({req, " deact id"}, deact_id, id);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 irq", irq, 0);
      chk("R1 ack_data", ack_data, 1023);
      chk("R1 ack pulse", ack_vld, 0);
      chk("R1 deact pulse", deact_vld, 0);
   endtask

   task automatic t_mask();
      cpu_en = 1'b1;
      mask   = PW'(50);
      cand(1, 7, 50);
      @(negedge clk);
      chk("R2 equal to mask not signalled", irq, 0);
      cand(1, 7, 49);
      chk("R2 below mask signalled", irq, 1);
      cpu_en = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R2 disabled line low", irq, 0);
      do_ack(1023, 0, "R2 disabled ack spurious");
      cpu_en = 1'b1;
      mask   = '1;
      @(negedge clk);
   endtask

   task automatic t_ack();
      cand(1, 33, 60);
      chk("R2 line up", irq, 1);
      do_ack(33, 1, "R3/R4");
      chk("R6 same candidate not resignalled", irq, 0);
      do_eoi(33, 1, "R7 single");
      chk("R7 candidate signalled again after eoi", irq, 1);
      cand(0, 0, 0);
   endtask

   task automatic t_spurious();
      cand(0, 12, 3);
      do_ack(1023, 0, "R5 no candidate");
      do_eoi(12, 0, "R5 nothing was pushed");
      cand(1, 12, 3);
      chk("R5 state unchanged, line rises", irq, 1);
      cand(0, 0, 0);
   endtask

   task automatic t_nest();
      cand(1, 100, 40); do_ack(100, 1, "R6 level1");
      cand(1, 101, 40); @(negedge clk);
      chk("R6 equal priority no preempt", irq, 0);
      cand(1, 102, 30); chk("R6 higher preempts", irq, 1);
      do_ack(102, 1, "R6 level2");
      cand(1, 103, 20); do_ack(103, 1, "R6 level3");
      cand(1, 104, 10); do_ack(104, 1, "R9 level4");
      cand(1, 105, 5);  @(negedge clk);
      chk("R9 full blocks line", irq, 0);
      do_ack(1023, 0, "R9 full ack spurious");
      do_eoi(104, 1, "R7 pop level4");
      chk("R9 room again, line rises", irq, 1);
      cand(0, 0, 0);
      do_eoi(100, 0, "R8 mismatch ignored");
      do_eoi(102, 0, "R8 not top ignored");
      do_eoi(103, 1, "R8 top still 103");
      cand(1, 106, 35); @(negedge clk);
      chk("R7 running back to 30", irq, 0);
      cand(1, 106, 29);
      chk("R7 beats restored 30", irq, 1);
      cand(0, 0, 0);
      do_eoi(102, 1, "R7 pop level2");
      do_eoi(100, 1, "R7 pop level1");
      cand(1, 107, 200);
      chk("R7 empty stack any masked-in", irq, 1);
      cand(0, 0, 0);
   endtask

   task automatic t_simul();
      cand(1, 200, 50); do_ack(200, 1, "R10 setup");
      cand(1, 201, 10);
      eoi_wr = 1'b1; eoi_id = ID_W'(200);
      do_ack(201, 1, "R10 ack processed");
      eoi_wr = 1'b0;
      chk("R10 eoi ignored", deact_vld, 0);
      cand(0, 0, 0);
      do_eoi(201, 1, "R10 unwind 201");
      do_eoi(200, 1, "R10 200 still active");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_ack();
      t_spurious();
      t_nest();
      t_simul();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule